// File: doc/BRIEF.md
# Address-Aware SECDED Codec for Flash Words

This block protects 64-bit flash words with eight check bits. The check bits cover the data and also the upper bits of the word's address, so a read that returns data from the wrong location is caught. On the write side, an encoder turns a data word and its address into the eight check bits that are stored next to the word. On the read side, a decoder takes the returned data, the address that was requested and the stored check bits. It fixes any single flipped data bit and reports a single-error flag, an uncorrectable-error flag and the raw syndrome.

The code is a Hamming code with seven position bits and one overall parity bit. The information bits are the 64 data bits followed by the address bits above bit 3. Address bits take part in the parity but are never corrected, so a syndrome that points at an address position is reported as uncorrectable. When the enable input is low, the decoder passes the raw data through and holds all of its flags at zero. The encoder is purely combinational. The decoder results can be registered by one clock stage, selected with the `REG_OUT` parameter, which defaults to 1.

Top module: `secded_codec`

## Requirements
- R1: `wr_chk[6:0]` is the XOR of the Hamming positions of all set information bits. Information bit i is data bit i for i < 64, and address bit (i - 60) for i >= 64. Positions are the integers from 3 upward that are not powers of two, taken in ascending order of i. `wr_chk[7]` is the XOR of all information bits and of `wr_chk[6:0]`.
- R2: Address bits [3:0] change neither the check bits nor any decoder output.
- R3: With the enable high and data, address and check bits all consistent, `rd_syndrome` is 0, both flags are 0 and `rd_fixed` equals `rd_data`.
- R4: A single flipped data bit is corrected. `rd_single` is 1, `rd_uncorr` is 0 and `rd_syndrome` is {1, position of that bit}.
- R5: A single flipped check bit leaves the data unchanged and sets `rd_single`. The syndrome is {1, 2^j} for bit j < 7, and {1, 0} for bit 7.
- R6: Any two flipped bits among data and check bits set `rd_uncorr`, clear `rd_single`, and pass the data through uncorrected.
- R7: A read address that differs from the written address in one or two bits of [AW-1:4] sets `rd_uncorr`.
- R8: With `ecc_en` low, `rd_fixed` equals `rd_data`, both flags are 0 and `rd_syndrome` is 0, whatever errors are present.
- R9: `rd_single` and `rd_uncorr` are never 1 together.
- R10: With `REG_OUT`=1, decoder outputs show the inputs of the previous rising edge. While `rst_n` is low, all decoder outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| ecc_en | input | 1 | Enable for checking and correction |
| wr_data | input | 64 | Data word to encode |
| wr_addr | input | AW (20) | Address of the word to encode |
| wr_chk | output | 8 | Check bits computed for the word |
| rd_data | input | 64 | Data as read from the array |
| rd_addr | input | AW (20) | Address that was requested |
| rd_chk | input | 8 | Check bits as read from the array |
| rd_fixed | output | 64 | Corrected (or raw) data |
| rd_single | output | 1 | A single error was corrected or absorbed |
| rd_uncorr | output | 1 | The error cannot be corrected |
| rd_syndrome | output | 8 | {overall parity, position syndrome} |

## Verification
The bench covers these corner cases:
- Errors at the extreme bit positions (data bits 0 and 63, check bits 0, 6 and 7). A position table that is off by one would fix the wrong bit, or miss these bits altogether.
- A single address fault. Its syndrome lands on a legal, non-power-of-two position with odd parity, so a decoder that treated that position as data would report a correctable error instead of an uncorrectable one.
- A data error paired with a check-bit error, and a double check-bit error. Both give even overall parity, which a decoder that looks only at the syndrome would miss.
- The bypass mode and the low address bits. These show whether a disabled decoder, or a decoder that reads bits [3:0], leaks flags or changes the data.

// File: rtl/secded_pkg.sv
package secded_pkg;

    localparam int unsigned SYN_W    = 7;
    localparam int unsigned CHK_W    = SYN_W + 1;
    localparam int unsigned INFO_MAX = (1 << SYN_W) - 1 - SYN_W;

    function automatic bit is_pow2(int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

    // Hamming position of information bit idx
    function automatic int unsigned slot_of(int unsigned idx);
        int unsigned p;
        p = 3;
        for (int unsigned k = 0; k < idx; k++) begin
            p++;
            if (is_pow2(p)) p++;
        end
        return p;
    endfunction

    // Shared parity matrix: XOR of positions of all set information bits
    function automatic logic [SYN_W-1:0] ham_bits(logic [INFO_MAX-1:0] info);
        logic [SYN_W-1:0] acc;
        int unsigned p;
        acc = '0;
        p   = 3;
        for (int unsigned i = 0; i < INFO_MAX; i++) begin
            if (info[i]) acc ^= SYN_W'(p);
            p++;
            if (is_pow2(p)) p++;
        end
        return acc;
    endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc
    import secded_pkg::*;
#(
    parameter int unsigned DW = 64,
    parameter int unsigned AW = 20
) (
    input  logic [DW-1:0]    data,
    input  logic [AW-1:0]    addr,
    output logic [CHK_W-1:0] chk
);
    localparam int unsigned AAW = AW - 4;

    logic [INFO_MAX-1:0] info;
    logic [SYN_W-1:0]    ham;

    always_comb begin
        info             = '0;
        info[DW-1:0]     = data;
        info[DW +: AAW]  = addr[AW-1:4];
        ham              = ham_bits(info);
        chk              = {(^info) ^ (^ham), ham};
    end

endmodule

// File: rtl/secded_dec.sv
module secded_dec
    import secded_pkg::*;
#(
    parameter int unsigned DW = 64,
    parameter int unsigned AW = 20
) (
    input  logic             en,
    input  logic [DW-1:0]    data,
    input  logic [AW-1:0]    addr,
    input  logic [CHK_W-1:0] chk,
    output logic [DW-1:0]    fixed,
    output logic             single,
    output logic             uncorr,
    output logic [CHK_W-1:0] syndrome
);
    localparam int unsigned AAW = AW - 4;

    logic [INFO_MAX-1:0] info;
    logic [SYN_W-1:0]    syn;
    logic                par;
    logic [DW-1:0]       hit;

    always_comb begin
        info            = '0;
        info[DW-1:0]    = data;
        info[DW +: AAW] = addr[AW-1:4];
        syn             = ham_bits(info) ^ chk[SYN_W-1:0];
        par             = (^info) ^ (^chk);
    end

    // One comparator per data bit against its fixed Hamming position
    for (genvar i = 0; i < DW; i++) begin : g_hit
        localparam logic [SYN_W-1:0] SLOT = SYN_W'(slot_of(i));
        assign hit[i] = (syn == SLOT);
    end

    always_comb begin
        fixed    = data;
        single   = 1'b0;
        uncorr   = 1'b0;
        syndrome = '0;
        if (en) begin
            syndrome = {par, syn};
            if (syn == '0) begin
                single = par;
            end else if (!par) begin
                uncorr = 1'b1;
            end else if (|hit) begin
                single = 1'b1;
                fixed  = data ^ hit;
            end else if ($onehot(syn)) begin
                single = 1'b1;
            end else begin
                uncorr = 1'b1;
            end
        end
    end

    always_comb begin
        AST_FLAGS_EXCLUSIVE: assert (!(single && uncorr)) else $error("both flags set"); // R9
    end

endmodule

// File: rtl/secded_ostage.sv
module secded_ostage #(
    parameter int unsigned W       = 74,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= d;
        end
    end else begin : g_wire
        assign q = d;
    end

endmodule

// File: rtl/secded_codec.sv
module secded_codec
    import secded_pkg::*;
#(
    parameter int unsigned DW      = 64,
    parameter int unsigned AW      = 20,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ecc_en,
    input  logic [DW-1:0]    wr_data,
    input  logic [AW-1:0]    wr_addr,
    output logic [CHK_W-1:0] wr_chk,
    input  logic [DW-1:0]    rd_data,
    input  logic [AW-1:0]    rd_addr,
    input  logic [CHK_W-1:0] rd_chk,
    output logic [DW-1:0]    rd_fixed,
    output logic             rd_single,
    output logic             rd_uncorr,
    output logic [CHK_W-1:0] rd_syndrome
);
    localparam int unsigned AAW   = AW - 4;
    localparam int unsigned OUT_W = DW + 2 + CHK_W;

    if (DW + AAW > INFO_MAX) begin : g_bad_size
        $error("data plus address bits exceed the code capacity");
    end

    logic [DW-1:0]    dec_fixed;
    logic             dec_single;
    logic             dec_uncorr;
    logic [CHK_W-1:0] dec_syn;

    secded_enc #(.DW(DW), .AW(AW)) u_enc (
        .data (wr_data),
        .addr (wr_addr),
        .chk  (wr_chk)
    );

    secded_dec #(.DW(DW), .AW(AW)) u_dec (
        .en       (ecc_en),
        .data     (rd_data),
        .addr     (rd_addr),
        .chk      (rd_chk),
        .fixed    (dec_fixed),
        .single   (dec_single),
        .uncorr   (dec_uncorr),
        .syndrome (dec_syn)
    );

    secded_ostage #(.W(OUT_W), .REG_OUT(REG_OUT)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({dec_fixed, dec_single, dec_uncorr, dec_syn}),
        .q     ({rd_fixed, rd_single, rd_uncorr, rd_syndrome})
    );

    AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_single && rd_uncorr)) else $error("single and uncorrectable together"); // R9

    if (REG_OUT) begin : g_chk
        AST_BYPASS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(ecc_en)) |->
            (rd_fixed == $past(rd_data) && !rd_single && !rd_uncorr && rd_syndrome == '0))
            else $error("bypass altered data or flags"); // R8

        AST_CLEAN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(ecc_en) && $past(rd_data == wr_data) &&
             $past(rd_addr[AW-1:4] == wr_addr[AW-1:4]) && $past(rd_chk == wr_chk)) |->
            (rd_syndrome == '0 && !rd_single && !rd_uncorr && rd_fixed == $past(rd_data)))
            else $error("consistent word flagged"); // R3

        AST_SINGLE_FIX: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(ecc_en) && $past(rd_addr == wr_addr) &&
             $past(rd_chk == wr_chk) && $past($countones(rd_data ^ wr_data) == 1)) |->
            (rd_single && !rd_uncorr && rd_fixed == $past(wr_data)))
            else $error("single data error not corrected"); // R4

        AST_DOUBLE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(ecc_en) && $past(rd_addr == wr_addr) &&
             $past(rd_chk == wr_chk) && $past($countones(rd_data ^ wr_data) == 2)) |->
            (rd_uncorr && !rd_single))
            else $error("double data error not flagged"); // R6

        AST_ADDR_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(ecc_en) && $past(rd_data == wr_data) &&
             $past(rd_chk == wr_chk) &&
             ($past($countones(rd_addr[AW-1:4] ^ wr_addr[AW-1:4]) == 1) ||
              $past($countones(rd_addr[AW-1:4] ^ wr_addr[AW-1:4]) == 2))) |->
            rd_uncorr)
            else $error("address fault not flagged"); // R7
    end

endmodule

// File: tb/sim_secded_codec.sv
module sim_secded_codec;

    localparam int DW = 64;
    localparam int AW = 20;
    localparam int VW = 103;
    localparam int NV = 15;

    // {data[64], addr[20], kind[3], i0[7], i1[7], exp_single, exp_uncorr}
    // kind: 0 clean, 1 data i0, 2 chk i0, 3 data i0+i1, 4 data i0 + chk i1,
    //       5 addr i0, 6 addr i0+i1, 7 chk i0+i1
    localparam logic [VW-1:0] VEC [NV] = '{
        {64'h0000000000000000, 20'h00000, 3'd0, 7'd0,  7'd0,  1'b0, 1'b0},
        {64'hFFFFFFFFFFFFFFFF, 20'hFFFFF, 3'd0, 7'd0,  7'd0,  1'b0, 1'b0},
        {64'h0123456789ABCDEF, 20'h12340, 3'd1, 7'd0,  7'd0,  1'b1, 1'b0},
        {64'h0123456789ABCDEF, 20'hABCD0, 3'd1, 7'd63, 7'd0,  1'b1, 1'b0},
        {64'hDEADBEEFCAFEF00D, 20'h00010, 3'd1, 7'd31, 7'd0,  1'b1, 1'b0},
        {64'h5555555555555555, 20'h55550, 3'd2, 7'd0,  7'd0,  1'b1, 1'b0},
        {64'h5555555555555555, 20'h55550, 3'd2, 7'd6,  7'd0,  1'b1, 1'b0},
        {64'hAAAAAAAAAAAAAAAA, 20'hAAAA0, 3'd2, 7'd7,  7'd0,  1'b1, 1'b0},
        {64'h0F0F0F0F0F0F0F0F, 20'h0F0F0, 3'd3, 7'd5,  7'd40, 1'b0, 1'b1},
        {64'h1122334455667788, 20'h11220, 3'd4, 7'd10, 7'd3,  1'b0, 1'b1},
        {64'h1122334455667788, 20'h11220, 3'd5, 7'd4,  7'd0,  1'b0, 1'b1},
        {64'h8877665544332211, 20'h88770, 3'd5, 7'd19, 7'd0,  1'b0, 1'b1},
        {64'h8877665544332211, 20'h00000, 3'd6, 7'd4,  7'd12, 1'b0, 1'b1},
        {64'hCAFEBABE00000000, 20'h3C3C0, 3'd7, 7'd2,  7'd7,  1'b0, 1'b1},
        {64'h8000000000000001, 20'hFFFF0, 3'd1, 7'd47, 7'd0,  1'b1, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ecc_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_chk;
    logic [DW-1:0] rd_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_chk = '0;
    logic [DW-1:0] rd_fixed;
    logic          rd_single;
    logic          rd_uncorr;
    logic [7:0]    rd_syndrome;

    int n_cmp  = 0;
    int n_bad  = 0;
    bit closed = 1'b0;
    int pos_of [120];

    always #2 clk = ~clk;

    secded_codec #(.DW(DW), .AW(AW), .REG_OUT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .ecc_en(ecc_en),
        .wr_data(wr_data), .wr_addr(wr_addr), .wr_chk(wr_chk),
        .rd_data(rd_data), .rd_addr(rd_addr), .rd_chk(rd_chk),
        .rd_fixed(rd_fixed), .rd_single(rd_single), .rd_uncorr(rd_uncorr),
        .rd_syndrome(rd_syndrome)
    );

    function automatic logic [7:0] ref_chk(logic [DW-1:0] d, logic [AW-1:0] a);
        logic [6:0] h;
        logic       all;
        h   = '0;
        all = 1'b0;
        for (int i = 0; i < DW + AW - 4; i++) begin
            logic b;
            b = (i < DW) ? d[i] : a[i - DW + 4];
            if (b) h ^= 7'(pos_of[i]);
            all ^= b;
        end
        return {all ^ (^h), h};
    endfunction

    task automatic check(string req, string what, logic [127:0] act, logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!closed) begin
            closed = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #800000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int idx;
        idx = 0;
        for (int p = 1; p < 128; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (idx < 120) pos_of[idx] = p;
                idx++;
            end
        end

        // R10: reset holds outputs at zero even with live inputs
        ecc_en  = 1'b1;
        rd_data = 64'hFFFF0000FFFF0000;
        rd_chk  = 8'hA5;
        repeat (3) @(posedge clk);
        #1;
        check("R10", "reset fixed", 128'(rd_fixed), 128'(0));
        check("R10", "reset flags", 128'({rd_single, rd_uncorr, rd_syndrome}), 128'(0));
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: R1 and R3..R7, R9 on every vector
        for (int v = 0; v < NV; v++) begin
            logic [DW-1:0] d, rdd;
            logic [AW-1:0] a, rda;
            logic [7:0]    c, rc, exp_syn;
            logic [2:0]    kind;
            int            i0, i1;
            logic          es, eu;
            d    = VEC[v][102:39];
            a    = VEC[v][38:19];
            kind = VEC[v][18:16];
            i0   = int'(VEC[v][15:9]);
            i1   = int'(VEC[v][8:2]);
            es   = VEC[v][1];
            eu   = VEC[v][0];
            @(negedge clk);
            ecc_en  = 1'b1;
            wr_data = d;
            wr_addr = a;
            #1;
            c = ref_chk(d, a);
            check("R1", "check bits", 128'(wr_chk), 128'(c));
            rdd = d;
            rda = a;
            rc  = c;
            case (kind)
                3'd1: rdd[i0] = ~rdd[i0];
                3'd2: rc[i0]  = ~rc[i0];
                3'd3: begin rdd[i0] = ~rdd[i0]; rdd[i1] = ~rdd[i1]; end
                3'd4: begin rdd[i0] = ~rdd[i0]; rc[i1]  = ~rc[i1];  end
                3'd5: rda[i0] = ~rda[i0];
                3'd6: begin rda[i0] = ~rda[i0]; rda[i1] = ~rda[i1]; end
                3'd7: begin rc[i0]  = ~rc[i0];  rc[i1]  = ~rc[i1];  end
                default: ;
            endcase
            rd_data = rdd;
            rd_addr = rda;
            rd_chk  = rc;
            @(posedge clk);
            #1;
            if (kind == 3'd0) begin
                check("R3", "clean flags", 128'({rd_single, rd_uncorr}), 128'(0));
                check("R3", "clean syndrome", 128'(rd_syndrome), 128'(0));
                check("R3", "clean data", 128'(rd_fixed), 128'(d));
            end else if (kind == 3'd1) begin
                exp_syn = {1'b1, 7'(pos_of[i0])};
                check("R4", "data fix flags", 128'({rd_single, rd_uncorr}), 128'({es, eu}));
                check("R4", "data fix value", 128'(rd_fixed), 128'(d));
                check("R4", "data fix syndrome", 128'(rd_syndrome), 128'(exp_syn));
            end else if (kind == 3'd2) begin
                exp_syn = (i0 == 7) ? 8'h80 : {1'b1, 7'(1 << i0)};
                check("R5", "check-bit flags", 128'({rd_single, rd_uncorr}), 128'({es, eu}));
                check("R5", "check-bit data", 128'(rd_fixed), 128'(d));
                check("R5", "check-bit syndrome", 128'(rd_syndrome), 128'(exp_syn));
            end else if (kind == 3'd5 || kind == 3'd6) begin
                check("R7", "address flags", 128'({rd_single, rd_uncorr}), 128'({es, eu}));
            end else begin
                check("R6", "double flags", 128'({rd_single, rd_uncorr}), 128'({es, eu}));
                check("R6", "double raw data", 128'(rd_fixed), 128'(rdd));
            end
            check("R9", "flag exclusivity", 128'(rd_single & rd_uncorr), 128'(0));
        end

        // R2: low address bits ignored by encoder and decoder
        begin
            logic [7:0] c0;
            @(negedge clk);
            wr_data = 64'h0BADF00D12345678;
            wr_addr = 20'h4C5A0;
            #1;
            c0 = wr_chk;
            wr_addr = 20'h4C5AF;
            #1;
            check("R2", "encoder low addr", 128'(wr_chk), 128'(c0));
            rd_data = 64'h0BADF00D12345678;
            rd_addr = 20'h4C5A9;
            rd_chk  = c0;
            @(posedge clk);
            #1;
            check("R2", "decoder low addr", 128'({rd_single, rd_uncorr, rd_syndrome}), 128'(0));
            check("R2", "decoder low addr data", 128'(rd_fixed), 128'(64'h0BADF00D12345678));
        end

        // R8: bypass passes raw data with a double error present
        @(negedge clk);
        ecc_en  = 1'b0;
        rd_data = 64'h0BADF00D12345678 ^ 64'h0000000000000011;
        @(posedge clk);
        #1;
        check("R8", "bypass data", 128'(rd_fixed), 128'(64'h0BADF00D12345669));
        check("R8", "bypass flags", 128'({rd_single, rd_uncorr, rd_syndrome}), 128'(0));

        // R10: output holds until the next rising edge
        @(negedge clk);
        rd_data = 64'h1111111111111111;
        #1;
        check("R10", "hold before edge", 128'(rd_fixed), 128'(64'h0BADF00D12345669));
        @(posedge clk);
        #1;
        check("R10", "update after edge", 128'(rd_fixed), 128'(64'h1111111111111111));

        summary();
    end

endmodule